// File: doc/BRIEF.md
# Two-Rail Ternary Storage Register

This block holds a word of ternary digits. Each trit sits on two binary storage bits: a plus rail and a minus rail. A trit has three legal encodings. Plus-high alone means +1, minus-high alone means -1, and both rails low means 0. Each trit has its own pair of set lines, and every cell in the word shares one clear line. All state changes take place on the rising clock edge.

Software or surrounding logic writes a trit by raising a set combination for one or more cycles and then dropping both lines. The cell then keeps the value. Raising both set lines together is a legal command, and it writes the zero state. A build parameter selects whether the shared clear line is honoured or ignored. The block reports an error flag if any cell ever holds both rails high.

Top module: `tern_reg`

## Requirements
- R1: While `rst` is high at a rising edge, every trit becomes (plus,minus)=(0,0) after that edge, whatever the set and clear lines carry, and `illegal_o` is low.
- R2: Set lines (plus,minus)=(1,0) on a trit at an edge make that trit (1,0) after the edge, whatever it held before.
- R3: Set lines (0,1) on a trit at an edge make that trit (0,1) after the edge, whatever it held before.
- R4: Set lines (1,1) on a trit at an edge make that trit (0,0) after the edge, whatever it held before.
- R5: Set lines (0,0) on a trit with clear inactive leave the trit unchanged, and this includes the zero state.
- R6: With `HAS_CLEAR`=1, `clr_i` high at an edge makes every trit (0,0) after that edge, and it overrides any set combination in the same cycle. The trits stay (0,0) after `clr_i` drops, as long as the set lines stay (0,0).
- R7: With `HAS_CLEAR`=0, `clr_i` has no effect. Every trit follows its set lines exactly as in R2 to R5.
- R8: The rail pair (1,1) never appears on a trit's outputs. `illegal_o` is high exactly when some trit holds (1,1).
- R9: Each trit updates only from its own set lines (bit i of `set_pos_i`/`set_neg_i` drives bit i of the outputs), together with the shared clear and reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of all trits |
| clr_i | input | 1 | Shared clear line (honoured only when HAS_CLEAR=1) |
| set_pos_i | input | NUM_TRITS | Plus set line per trit |
| set_neg_i | input | NUM_TRITS | Minus set line per trit |
| q_pos_o | output | NUM_TRITS | Plus rail per trit |
| q_neg_o | output | NUM_TRITS | Minus rail per trit |
| illegal_o | output | 1 | High when any trit holds both rails high |

## Verification
Two functions can coincide in one cycle: a set combination on a trit and the shared clear, or a set combination and the reset. The bench sweeps every set vector of a three-trit word from each of the 27 prior states, once with the clear high and once with it low. The same stimulus drives a copy built without the clear. For the copy with the clear, the judgement is that the clear wins on every trit. For the copy without it, the judgement is that each trit follows its set lines as if the clear were absent. A reset held together with active set lines must likewise leave every trit at zero.

// File: rtl/tern_reg_pkg.sv
package tern_reg_pkg;

    // One trit held on two binary rails
    typedef struct packed {
        logic pos;
        logic neg;
    } rail_pair_t;

    // Decoded write command from a pair of set lines
    typedef enum logic [1:0] {
        CMD_KEEP  = 2'd0,
        CMD_PLUS  = 2'd1,
        CMD_MINUS = 2'd2,
        CMD_ZERO  = 2'd3
    } set_cmd_e;

    localparam rail_pair_t RAIL_ZERO  = '{pos: 1'b0, neg: 1'b0};
    localparam rail_pair_t RAIL_PLUS  = '{pos: 1'b1, neg: 1'b0};
    localparam rail_pair_t RAIL_MINUS = '{pos: 1'b0, neg: 1'b1};

    function automatic set_cmd_e decode_set(input logic sp, input logic sn);
        set_cmd_e c;
        case ({sp, sn})
            2'b10:   c = CMD_PLUS;
            2'b01:   c = CMD_MINUS;
            2'b11:   c = CMD_ZERO;
            default: c = CMD_KEEP;
        endcase
        return c;
    endfunction

    function automatic rail_pair_t cmd_target(input set_cmd_e c, input rail_pair_t cur);
        rail_pair_t t;
        case (c)
            CMD_PLUS:  t = RAIL_PLUS;
            CMD_MINUS: t = RAIL_MINUS;
            CMD_ZERO:  t = RAIL_ZERO;
            default:   t = cur;
        endcase
        return t;
    endfunction

    function automatic logic rail_bad(input rail_pair_t r);
        return r.pos & r.neg;
    endfunction

endpackage

// File: rtl/tern_cell.sv
module tern_cell
    import tern_reg_pkg::*;
#(
    parameter bit HAS_CLEAR = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       set_pos,
    input  logic       set_neg,
    output rail_pair_t q
);

    localparam logic CLR_EN = HAS_CLEAR;

    logic       clr_eff;
    set_cmd_e   cmd;
    rail_pair_t q_next;

    assign clr_eff = clr & CLR_EN;
    assign cmd     = decode_set(set_pos, set_neg);

    always_comb begin
        if (clr_eff) begin
            q_next = RAIL_ZERO;
        end else begin
            q_next = cmd_target(cmd, q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RAIL_ZERO;
        end else begin
            q <= q_next;
        end
    end

    // R1: reset forces zero regardless of set lines
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (q == RAIL_ZERO));

    // R5: idle set lines with no clear keep the stored value
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_eff && !set_pos && !set_neg) |=> $stable(q));

    // R8: the cell never holds both rails high
    a_r8_rails_legal: assert property (@(posedge clk) disable iff (rst)
        !(q.pos && q.neg));

    if (HAS_CLEAR) begin : g_with_clear
        // R6: clear wins over every set combination
        a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
            clr |=> (q == RAIL_ZERO));
        // R2: plus command without clear
        a_r2_plus: assert property (@(posedge clk) disable iff (rst)
            (!clr && set_pos && !set_neg) |=> (q == RAIL_PLUS));
        // R3: minus command without clear
        a_r3_minus: assert property (@(posedge clk) disable iff (rst)
            (!clr && !set_pos && set_neg) |=> (q == RAIL_MINUS));
        // R4: both set lines write zero
        a_r4_both_zero: assert property (@(posedge clk) disable iff (rst)
            (!clr && set_pos && set_neg) |=> (q == RAIL_ZERO));
    end else begin : g_no_clear
        // R7 with R2: clear line is ignored
        a_r7_plus_ignores_clr: assert property (@(posedge clk) disable iff (rst)
            (set_pos && !set_neg) |=> (q == RAIL_PLUS));
        // R7 with R3
        a_r7_minus_ignores_clr: assert property (@(posedge clk) disable iff (rst)
            (!set_pos && set_neg) |=> (q == RAIL_MINUS));
        // R7 with R4
        a_r7_zero_ignores_clr: assert property (@(posedge clk) disable iff (rst)
            (set_pos && set_neg) |=> (q == RAIL_ZERO));
    end

endmodule

// File: rtl/tern_err_detect.sv
module tern_err_detect
    import tern_reg_pkg::*;
#(
    parameter int NUM_TRITS = 4
) (
    input  rail_pair_t cells [NUM_TRITS],
    output logic       any_bad
);

    always_comb begin
        any_bad = 1'b0;
        for (int i = 0; i < NUM_TRITS; i++) begin
            any_bad = any_bad | rail_bad(cells[i]);
        end
    end

endmodule

// File: rtl/tern_reg.sv
module tern_reg
    import tern_reg_pkg::*;
#(
    parameter int NUM_TRITS = 4,
    parameter bit HAS_CLEAR = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_i,
    input  logic [NUM_TRITS-1:0] set_pos_i,
    input  logic [NUM_TRITS-1:0] set_neg_i,
    output logic [NUM_TRITS-1:0] q_pos_o,
    output logic [NUM_TRITS-1:0] q_neg_o,
    output logic                 illegal_o
);

    rail_pair_t cell_q [NUM_TRITS];

    for (genvar i = 0; i < NUM_TRITS; i++) begin : g_cell
        tern_cell #(
            .HAS_CLEAR(HAS_CLEAR)
        ) cell_i (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr_i),
            .set_pos (set_pos_i[i]),
            .set_neg (set_neg_i[i]),
            .q       (cell_q[i])
        );
        assign q_pos_o[i] = cell_q[i].pos;
        assign q_neg_o[i] = cell_q[i].neg;
    end

    tern_err_detect #(
        .NUM_TRITS(NUM_TRITS)
    ) err_i (
        .cells   (cell_q),
        .any_bad (illegal_o)
    );

    // R8: no trit drives both rails at the ports
    a_r8_ports_legal: assert property (@(posedge clk) disable iff (rst)
        ((q_pos_o & q_neg_o) == '0) && !illegal_o);

    // R1: reset leaves the error flag low
    a_r1_flag_clear: assert property (@(posedge clk)
        rst |=> !illegal_o);

endmodule

// File: tb/tern_reg_tb_top.sv
module tern_reg_tb_top;

    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst;
    logic         clr;
    logic [N-1:0] sp;
    logic [N-1:0] sn;
    logic [N-1:0] qp_a, qn_a, qp_b, qn_b;
    logic         ill_a, ill_b;

    int model_a [N];
    int model_b [N];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tern_reg #(.NUM_TRITS(N), .HAS_CLEAR(1'b1)) dut_i (
        .clk(clk), .rst(rst), .clr_i(clr), .set_pos_i(sp), .set_neg_i(sn),
        .q_pos_o(qp_a), .q_neg_o(qn_a), .illegal_o(ill_a));

    tern_reg #(.NUM_TRITS(N), .HAS_CLEAR(1'b0)) dut_nc_i (
        .clk(clk), .rst(rst), .clr_i(clr), .set_pos_i(sp), .set_neg_i(sn),
        .q_pos_o(qp_b), .q_neg_o(qn_b), .illegal_o(ill_b));

    function automatic int next_val(input int cur, input logic p, input logic n);
        if (p && !n) return 1;
        if (!p && n) return -1;
        if (p && n) return 0;
        return cur;
    endfunction

    task automatic check(input string req);
        logic [N-1:0] ep_a, en_a, ep_b, en_b;
        for (int i = 0; i < N; i++) begin
            ep_a[i] = (model_a[i] == 1);
            en_a[i] = (model_a[i] == -1);
            ep_b[i] = (model_b[i] == 1);
            en_b[i] = (model_b[i] == -1);
        end
        checks++;
        if (qp_a !== ep_a || qn_a !== en_a || ill_a !== 1'b0) begin
            fails++;
            $display("FAIL %s R9 dut_i: pos=%b neg=%b ill=%b expected pos=%b neg=%b ill=0",
                     req, qp_a, qn_a, ill_a, ep_a, en_a);
        end
        checks++;
        if (qp_b !== ep_b || qn_b !== en_b || ill_b !== 1'b0) begin
            fails++;
            $display("FAIL %s R7 dut_nc_i: pos=%b neg=%b ill=%b expected pos=%b neg=%b ill=0",
                     req, qp_b, qn_b, ill_b, ep_b, en_b);
        end
    endtask

    // Drive inputs, take one edge, update the models and compare
    task automatic cycle(input logic [N-1:0] p, input logic [N-1:0] n,
                         input logic c, input logic r, input string req);
        sp  = p;
        sn  = n;
        clr = c;
        rst = r;
        @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) begin
            if (r) begin
                model_a[i] = 0;
                model_b[i] = 0;
            end else begin
                model_a[i] = c ? 0 : next_val(model_a[i], p[i], n[i]);
                model_b[i] = next_val(model_b[i], p[i], n[i]);
            end
        end
        check(req);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] lp, ln, vp, vn;
        int           d;
        int           pw;
        rst = 1'b1;
        clr = 1'b0;
        sp  = '0;
        sn  = '0;
        for (int i = 0; i < N; i++) begin
            model_a[i] = 0;
            model_b[i] = 0;
        end
        // R1: reset state
        cycle('0, '0, 1'b0, 1'b1, "R1 reset");
        cycle('0, '0, 1'b0, 1'b0, "R1 R5 idle after reset");

        // Sweep every prior state, every set vector, clear low and high
        for (int prior = 0; prior < 27; prior++) begin
            for (int vec = 0; vec < 64; vec++) begin
                for (int c = 0; c < 2; c++) begin
                    pw = 1;
                    for (int i = 0; i < N; i++) begin
                        d = ((prior / pw) % 3) - 1;
                        pw = pw * 3;
                        lp[i] = (d == 1)  || (d == 0);
                        ln[i] = (d == -1) || (d == 0);
                        vp[i] = vec[2*i+1];
                        vn[i] = vec[2*i];
                    end
                    cycle(lp, ln, 1'b0, 1'b0, "R2 R3 R4 load");
                    if (c == 1)
                        cycle(vp, vn, 1'b1, 1'b0, "R6 clear with sets");
                    else
                        cycle(vp, vn, 1'b0, 1'b0, "R2 R3 R4 overwrite");
                    cycle('0, '0, 1'b0, 1'b0, "R5 R6 hold after release");
                end
            end
        end

        // R1: reset overrides active set lines and clear
        cycle('1, '0, 1'b0, 1'b0, "R2 all plus");
        cycle('0, '1, 1'b1, 1'b1, "R1 reset with sets");
        cycle('0, '0, 1'b0, 1'b0, "R1 R5 hold zero");
        // R8: flag stays low through mixed traffic
        cycle(3'b101, 3'b011, 1'b0, 1'b0, "R8 mixed");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule